// File: doc/BRIEF.md
# NAND Block Erase Command Sequencer

This block sits on the host side of a small-page NAND flash bus and erases one block, or sends the device reset command. A request from the user side starts an operation. The user side also supplies a block number and a density select that chooses between the smaller and larger address widths. The sequencer drives the command-latch, address-latch, write-enable and read-enable strobes and the 8-bit I/O bus. Each bus cycle is built from a fixed count of strobe-low clocks followed by a fixed count of strobe-high clocks.

An erase has four parts. The sequencer sends the erase setup code and then the row address bytes, which hold only the block number; page and column bits are not sent. It then sends the confirm code and waits for the ready/busy line to return high. Last, it sends the read-status command and reads back the status byte, whose bit 0 reports an error. A reset sends the reset code, waits for ready, and reads the status in the same way. A time-out counter guards every busy wait.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, and at every idle time, we_n and re_n are 1, cle, ale, io_oe, busy and done are 0.
- R2: An accepted erase request first issues one command cycle (cle=1, ale=0) carrying 0x60.
- R3: After the setup code, an erase sends exactly 2 address cycles (ale=1, cle=0) when big_density=0 and exactly 3 when big_density=1.
- R4: The address bytes, in order, are {blk_addr[2:0],5'b0}, then blk_addr[10:3], then {6'b0,blk_addr[12:11]}. Bits 7:2 of the final address byte are forced to 0, so with big_density=0 the second byte is {6'b0,blk_addr[4:3]}.
- R5: After the address cycles comes one command cycle with 0xD0. The status command 0x70 is issued only after rb_n has been seen high again.
- R6: The status byte is read with a re_n-low cycle and io_oe=0. fail equals bit 0 of that byte, and it is valid while done=1.
- R7: An accepted reset request issues the single command 0xFF, waits for rb_n high, then issues 0x70 and reads status as in R6.
- R8: If rb_n stays low for BUSY_TIMEOUT clocks of a busy wait, the sequencer skips the status read and ends with timed_out=1 and fail=1.
- R9: Every write-enable or read-enable pulse is low for exactly STROBE_LOW clocks. Exactly one of cle and ale is high while we_n is low, and neither changes during the pulse.
- R10: busy is 1 from the clock after a request is accepted until done. done is a one-clock pulse. Requests that arrive while busy=1 have no effect. When both requests arrive together while idle, the reset request wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_erase | input | 1 | Start a block erase (taken when idle) |
| req_reset | input | 1 | Start a device reset (taken when idle, wins over erase) |
| big_density | input | 1 | 1 selects three address cycles, 0 selects two |
| blk_addr | input | BLK_W | Block number to erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse at the end of an operation |
| fail | output | 1 | Status error bit or time-out of the last operation |
| timed_out | output | 1 | Last operation ended on the busy time-out |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| io_out | output | 8 | Byte driven onto the flash I/O bus |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 8 | Byte read from the flash I/O bus |
| rb_n | input | 1 | Ready/busy from the flash, low while busy |

## Verification
The bench builds the sequencer with a two-clock strobe-low phase, a one-clock high phase, a two-clock settle delay and a 40-clock busy time-out. With these values an erase completes in a few dozen clocks. A flash model whose busy time is set per test can hold rb_n low past the time-out, which exercises the time-out path next to normal completions. It can also keep rb_n low long enough to show that the status command waits for ready. The short strobe phases leave room for requests injected in the middle of an operation, so the bench can show they are ignored.

// File: rtl/nand_erase_pkg.sv
`timescale 1ns/1ps
package nand_erase_pkg;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_DEV_RESET   = 8'hFF;

  // low row-address bits carried in the first row byte that are not block bits
  localparam int ROW_SKIP   = 5;
  // bits of the final address byte that may be nonzero
  localparam logic [7:0] FINAL_MASK = 8'h03;
  localparam int ERR_BIT    = 0;

  typedef enum logic [1:0] {CY_CMD, CY_ADDR, CY_READ} cyc_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_CONF, S_RSTCMD,
    S_WAIT, S_STCMD, S_STRD, S_DONE
  } seq_state_t;

  function automatic logic [1:0] addr_cycles(input logic big);
    return big ? 2'd3 : 2'd2;
  endfunction

  // byte idx of the row address built from a block number
  function automatic logic [7:0] row_byte(input logic [31:0] blk,
                                          input logic [1:0]  idx,
                                          input logic        is_last);
    logic [39:0] row;
    logic [7:0]  b;
    row = {8'b0, blk} << ROW_SKIP;
    b   = row[{idx, 3'b000} +: 8];
    return is_last ? (b & FINAL_MASK) : b;
  endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
`timescale 1ns/1ps
module nand_bus_cycle
  import nand_erase_pkg::*;
#(
  parameter int STROBE_LOW  = 2,
  parameter int STROBE_HIGH = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  cyc_kind_t  kind,
  input  logic [7:0] data,
  input  logic [7:0] io_in,
  output logic       idle,
  output logic       cyc_done,
  output logic [7:0] rd_byte,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe
);
  localparam int MAXPH = (STROBE_LOW > STROBE_HIGH) ? STROBE_LOW : STROBE_HIGH;
  localparam int CW    = $clog2(MAXPH) + 1;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  phase_t     phase;
  cyc_kind_t  kind_q;
  logic [7:0] data_q;
  logic [CW-1:0] cnt;
  logic       low_end, high_end;

  assign low_end  = (phase == PH_LOW)  && (cnt == CW'(STROBE_LOW - 1));
  assign high_end = (phase == PH_HIGH) && (cnt == CW'(STROBE_HIGH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      kind_q  <= CY_CMD;
      data_q  <= '0;
      cnt     <= '0;
      rd_byte <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_LOW;
          kind_q <= kind;
          data_q <= data;
          cnt    <= '0;
        end
        PH_LOW: if (low_end) begin
          phase <= PH_HIGH;
          cnt   <= '0;
          if (kind_q == CY_READ) rd_byte <= io_in;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_HIGH: if (high_end) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle     = (phase == PH_IDLE);
  assign cyc_done = high_end;
  assign cle      = (phase != PH_IDLE) && (kind_q == CY_CMD);
  assign ale      = (phase != PH_IDLE) && (kind_q == CY_ADDR);
  assign we_n     = !((phase == PH_LOW) && (kind_q != CY_READ));
  assign re_n     = !((phase == PH_LOW) && (kind_q == CY_READ));
  assign io_oe    = (phase != PH_IDLE) && (kind_q != CY_READ);
  assign io_out   = io_oe ? data_q : 8'h00;

  // R9: strobes never overlap, latch enables exclusive
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  p_latch_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R9: latch lines and data stay put across a write pulse
  p_ctrl_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(cle) && $stable(ale) && $stable(io_out)));
  // R6: reading never drives the bus
  p_read_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);

endmodule

// File: rtl/nand_busy_wait.sv
`timescale 1ns/1ps
module nand_busy_wait #(
  parameter int SETTLE_CLKS  = 2,
  parameter int BUSY_TIMEOUT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb_n,
  output logic idle,
  output logic wait_done,
  output logic wait_tmo
);
  localparam int MAXC = (SETTLE_CLKS > BUSY_TIMEOUT) ? SETTLE_CLKS : BUSY_TIMEOUT;
  localparam int CW   = $clog2(MAXC) + 1;

  typedef enum logic [1:0] {W_IDLE, W_SETTLE, W_WATCH} wphase_t;

  wphase_t wph;
  logic [CW-1:0] cnt;
  logic settle_end, limit_hit;

  assign settle_end = (wph == W_SETTLE) && (cnt == CW'(SETTLE_CLKS - 1));
  assign limit_hit  = (cnt == CW'(BUSY_TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wph <= W_IDLE;
      cnt <= '0;
    end else begin
      case (wph)
        W_IDLE: if (start) begin
          wph <= W_SETTLE;
          cnt <= '0;
        end
        W_SETTLE: if (settle_end) begin
          wph <= W_WATCH;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        W_WATCH: if (rb_n || limit_hit) begin
          wph <= W_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: wph <= W_IDLE;
      endcase
    end
  end

  assign idle      = (wph == W_IDLE);
  assign wait_done = (wph == W_WATCH) && (rb_n || limit_hit);
  assign wait_tmo  = (wph == W_WATCH) && !rb_n && limit_hit;

  // R5: a normal exit only happens with the device ready
  p_ready_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_done && !wait_tmo) |-> rb_n);
  // R8: a time-out only happens while the device is still busy
  p_tmo_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_tmo |-> (!rb_n && wait_done));

endmodule

// File: rtl/nand_erase_seq.sv
`timescale 1ns/1ps
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLK_W        = 13,
  parameter int STROBE_LOW   = 2,
  parameter int STROBE_HIGH  = 1,
  parameter int SETTLE_CLKS  = 2,
  parameter int BUSY_TIMEOUT = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_erase,
  input  logic             req_reset,
  input  logic             big_density,
  input  logic [BLK_W-1:0] blk_addr,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             timed_out,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  input  logic [7:0]       io_in,
  input  logic             rb_n
);
  seq_state_t       state;
  logic [BLK_W-1:0] blk_q;
  logic             big_q;
  logic [1:0]       aidx;
  logic             fail_q, tmo_q;

  // events brought out for assertions
  logic       cyc_start, cyc_idle, cyc_done;
  logic       wt_start, wt_idle, wt_done, wt_tmo;
  logic       addr_last, bus_state;
  cyc_kind_t  cyc_kind;
  logic [7:0] cyc_data;
  logic [7:0] rd_byte;
  logic       rd_unused_bits;

  assign rd_unused_bits = ^rd_byte[7:1];

  assign addr_last = (state == S_ADDR) && (aidx == addr_cycles(big_q) - 2'd1);
  assign bus_state = (state == S_SETUP) || (state == S_ADDR) || (state == S_CONF) ||
                     (state == S_RSTCMD) || (state == S_STCMD) || (state == S_STRD);
  assign cyc_start = bus_state && cyc_idle;
  assign wt_start  = (state == S_WAIT) && wt_idle && !wt_done;

  always_comb begin
    cyc_kind = CY_CMD;
    cyc_data = 8'h00;
    case (state)
      S_SETUP:  cyc_data = OP_ERASE_SETUP;
      S_ADDR: begin
        cyc_kind = CY_ADDR;
        cyc_data = row_byte(32'(blk_q), aidx, addr_last);
      end
      S_CONF:   cyc_data = OP_ERASE_GO;
      S_RSTCMD: cyc_data = OP_DEV_RESET;
      S_STCMD:  cyc_data = OP_STATUS;
      S_STRD:   cyc_kind = CY_READ;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      blk_q  <= '0;
      big_q  <= 1'b0;
      aidx   <= '0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_reset) begin
            state  <= S_RSTCMD;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
          end else if (req_erase) begin
            state  <= S_SETUP;
            blk_q  <= blk_addr;
            big_q  <= big_density;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
          end
        end
        S_SETUP: if (cyc_done) begin
          state <= S_ADDR;
          aidx  <= '0;
        end
        S_ADDR: if (cyc_done) begin
          if (addr_last) state <= S_CONF;
          else           aidx  <= aidx + 2'd1;
        end
        S_CONF, S_RSTCMD: if (cyc_done) state <= S_WAIT;
        S_WAIT: if (wt_done) begin
          if (wt_tmo) begin
            tmo_q  <= 1'b1;
            fail_q <= 1'b1;
            state  <= S_DONE;
          end else begin
            state  <= S_STCMD;
          end
        end
        S_STCMD: if (cyc_done) state <= S_STRD;
        S_STRD: if (cyc_done) begin
          fail_q <= rd_byte[ERR_BIT];
          state  <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  nand_bus_cycle #(
    .STROBE_LOW (STROBE_LOW),
    .STROBE_HIGH(STROBE_HIGH)
  ) u_cycle (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cyc_start),
    .kind    (cyc_kind),
    .data    (cyc_data),
    .io_in   (io_in),
    .idle    (cyc_idle),
    .cyc_done(cyc_done),
    .rd_byte (rd_byte),
    .cle     (cle),
    .ale     (ale),
    .we_n    (we_n),
    .re_n    (re_n),
    .io_out  (io_out),
    .io_oe   (io_oe)
  );

  nand_busy_wait #(
    .SETTLE_CLKS (SETTLE_CLKS),
    .BUSY_TIMEOUT(BUSY_TIMEOUT)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (wt_start),
    .rb_n     (rb_n),
    .idle     (wt_idle),
    .wait_done(wt_done),
    .wait_tmo (wt_tmo)
  );

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign fail      = fail_q;
  assign timed_out = tmo_q;

  // R10: done lasts one clock and only ends a running operation
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R1: idle means a quiet bus
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && re_n && !cle && !ale && !io_oe));
  // R4: the final address byte has its upper six bits low
  p_final_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !we_n && addr_last) |-> (io_out[7:2] == 6'b0));
  // R8: a time-out always reports failure
  p_tmo_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timed_out) |-> fail);
  // R5: status command goes out only with the device ready
  p_status_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STCMD && cle && !we_n) |-> rb_n);

endmodule

// File: tb/test_nand_erase_seq.sv
`timescale 1ns/1ps
module test_nand_erase_seq;
  localparam int BW   = 13;
  localparam int SLOW = 2;
  localparam int TMO  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_erase = 1'b0, req_reset = 1'b0, big_density = 1'b0;
  logic [BW-1:0] blk_addr = '0;
  logic busy, done, fail, timed_out, cle, ale, we_n, re_n, io_oe;
  logic [7:0] io_out, io_in;
  logic rb_n;

  always #4 clk = ~clk;

  nand_erase_seq #(.BLK_W(BW), .STROBE_LOW(SLOW), .STROBE_HIGH(1),
                   .SETTLE_CLKS(2), .BUSY_TIMEOUT(TMO)) i_nand_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_erase(req_erase), .req_reset(req_reset),
    .big_density(big_density), .blk_addr(blk_addr), .busy(busy), .done(done),
    .fail(fail), .timed_out(timed_out), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n));

  int nchk = 0, nfail = 0;

  // flash model and bus log
  logic [9:0] lg [32];
  int  nlog = 0;
  int  busy_cnt = 0, busy_len_cfg = 0;
  logic stat_cfg = 1'b0;
  logic we_prev = 1'b1, re_prev = 1'b1;
  int  low_cnt = 0, width_err = 0, latch_err = 0, stat_early = 0;

  assign rb_n  = (busy_cnt == 0);
  assign io_in = !re_n ? {1'b1, 6'b100000, stat_cfg} : 8'h00;

  always @(negedge clk) begin
    if (!we_n || !re_n) begin
      low_cnt = low_cnt + 1;
      if (!we_n && !((cle && !ale) || (ale && !cle))) latch_err = latch_err + 1;
    end
    if ((we_n && !we_prev) || (re_n && !re_prev)) begin
      if (low_cnt != SLOW) width_err = width_err + 1;
      low_cnt = 0;
    end
    if (we_n && !we_prev) begin
      if (nlog < 32) lg[nlog] = {cle, ale, io_out};
      nlog = nlog + 1;
      if (cle && (io_out == 8'hD0 || io_out == 8'hFF)) busy_cnt = busy_len_cfg;
      else if (cle && io_out == 8'h70 && busy_cnt != 0) stat_early = stat_early + 1;
    end else if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
    end
    we_prev = we_n;
    re_prev = re_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_addr(input logic [12:0] b, input int i, input logic big);
    if (i == 0) return {b[2:0], 5'b00000};
    if (i == 1) return big ? b[10:3] : {6'b0, b[4:3]};
    return {6'b0, b[12:11]};
  endfunction

  logic got_fail, got_tmo;

  task automatic run_op(input bit do_rst, input bit both, input logic big,
                        input logic [12:0] b, input int blen, input logic st,
                        input bit intrude);
    int guard;
    busy_len_cfg = blen;
    stat_cfg = st;
    nlog = 0;
    @(negedge clk);
    big_density = big; blk_addr = b;
    req_reset = do_rst | both; req_erase = !do_rst | both;
    @(negedge clk);
    req_reset = 0; req_erase = 0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (intrude) begin
      repeat (6) @(negedge clk);
      req_reset = 1; req_erase = 1; blk_addr = ~b; big_density = ~big;
      @(negedge clk);
      req_reset = 0; req_erase = 0;
    end
    guard = 0;
    while (!done && guard < 4000) begin @(negedge clk); guard++; end
    chk(guard < 4000, "R10 watchdog on done", guard, 0);
    got_fail = fail; got_tmo = timed_out;
    @(negedge clk);
    chk(!done && !busy, "R10 done one clock", {done, busy}, 0);
    guard = 0;
    while (!rb_n && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  // {big, blk, busy clocks, status error bit}
  localparam logic [22:0] VEC [6] = '{
    {1'b1, 13'h1ABC, 8'd12, 1'b0},
    {1'b0, 13'h0015, 8'd5,  1'b0},
    {1'b1, 13'h1FFF, 8'd20, 1'b1},
    {1'b0, 13'h1FFF, 8'd3,  1'b1},
    {1'b1, 13'h0000, 8'd1,  1'b0},
    {1'b0, 13'h0A5A, 8'd30, 1'b0}
  };

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(we_n && re_n && !cle && !ale && !io_oe && !busy && !done,
        "R1 reset outputs", {we_n, re_n, cle, ale, io_oe, busy, done}, 7'b1100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(we_n && re_n && !busy, "R1 idle after reset", {we_n, re_n, busy}, 3'b110);

    for (int v = 0; v < 6; v++) begin
      logic big; logic [12:0] b; int blen; logic st; int na;
      {big, b, blen, st} = {VEC[v][22], VEC[v][21:9], 32'(VEC[v][8:1]), VEC[v][0]};
      na = big ? 3 : 2;
      run_op(0, 0, big, b, blen, st, 0);
      chk(nlog == na + 3, "R3 cycle count", nlog, na + 3);
      chk(lg[0] == {2'b10, 8'h60}, "R2 setup code", lg[0], {2'b10, 8'h60});
      for (int i = 0; i < na; i++)
        chk(lg[1 + i] == {2'b01, exp_addr(b, i, big)}, "R4 address byte",
            lg[1 + i], {2'b01, exp_addr(b, i, big)});
      chk(lg[na + 1] == {2'b10, 8'hD0}, "R5 confirm code", lg[na + 1], {2'b10, 8'hD0});
      chk(lg[na + 2] == {2'b10, 8'h70}, "R5 status command", lg[na + 2], {2'b10, 8'h70});
      chk(got_fail == st && !got_tmo, "R6 status error bit", {got_fail, got_tmo}, {st, 1'b0});
    end
    chk(stat_early == 0, "R5 status only after ready", stat_early, 0);

    // R7 device reset
    run_op(1, 0, 0, 13'h0, 8, 0, 0);
    chk(nlog == 2, "R7 reset cycle count", nlog, 2);
    chk(lg[0] == {2'b10, 8'hFF}, "R7 reset code", lg[0], {2'b10, 8'hFF});
    chk(lg[1] == {2'b10, 8'h70}, "R7 status after reset", lg[1], {2'b10, 8'h70});
    chk(!got_fail, "R7 reset pass", got_fail, 0);

    // R8 time-out: busy far longer than the limit
    run_op(0, 0, 1, 13'h0123, 100, 0, 0);
    chk(got_tmo && got_fail, "R8 timeout flags", {got_tmo, got_fail}, 2'b11);
    chk(nlog == 5, "R8 no status read", nlog, 5);
    chk(stat_early == 0, "R5 no status while busy", stat_early, 0);

    // R10 requests mid-operation are ignored
    run_op(0, 0, 1, 13'h0F0F, 6, 0, 1);
    chk(nlog == 6, "R10 ignored request count", nlog, 6);
    chk(lg[1] == {2'b01, exp_addr(13'h0F0F, 0, 1)}, "R10 address unchanged",
        lg[1], {2'b01, exp_addr(13'h0F0F, 0, 1)});
    chk(lg[3] == {2'b01, exp_addr(13'h0F0F, 2, 1)}, "R10 third byte unchanged",
        lg[3], {2'b01, exp_addr(13'h0F0F, 2, 1)});
    repeat (20) @(negedge clk);
    chk(nlog == 6 && !busy, "R10 nothing after done", nlog, 6);

    // R10 reset wins over erase
    run_op(0, 1, 1, 13'h0055, 4, 1, 0);
    chk(lg[0] == {2'b10, 8'hFF}, "R10 reset priority", lg[0], {2'b10, 8'hFF});
    chk(nlog == 2 && got_fail, "R10 reset path status", {nlog[3:0], got_fail}, 5'b00101);

    // R9 strobe widths and latch lines across the whole run
    chk(width_err == 0, "R9 strobe low width", width_err, 0);
    chk(latch_err == 0, "R9 latch select", latch_err, 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule